// File: doc/BRIEF.md
# Row Buffer Persistence Controller

This block drives one bank of a non-volatile memory array. A latching row buffer and a background shadow buffer sit between the array and the command interface. An activate command opens a row by copying it from the array into the row buffer. Every read and write column access is then served from that buffer. A write changes the buffer and also gives a full copy of the updated row to the shadow buffer. The shadow buffer writes that copy back into the array a fixed number of cycles later, while column traffic continues.

The persistence latency is fixed and known in advance. There is no refresh. Every timing gap (activate to column, column read to data, activate to precharge, precharge to activate, write to precharge, write to persistence) is given in picoseconds and turned into clock cycles by rounding up. Commands that break a gap are refused and reported. The array sits behind a simple synchronous port: a read request returns its row on the next clock edge, and a write request stores its row on the edge where it is asserted.

Top module: `rbp_ctrl`

## Requirements
- R1: An activate to this bank, with no row open and the precharge gap elapsed, asserts `arr_rd_en` with `arr_rd_row` equal to the command row in the same cycle. After that the row buffer holds that array row.
- R2: A legal read makes `rd_valid` high for exactly one cycle, carrying the row buffer word selected by `cmd_col`. Word c occupies row bits [c*DW +: DW]. It appears ceil(tAA/clock) - 1 edges after the edge that accepts the read (the cycle right after that edge at default settings).
- R3: A legal write replaces the selected word of the row buffer, and a read in the following cycle returns the new word.
- R4: A legal write makes `busy` high from the next cycle on. Exactly ceil(tPERSIST/clock) edges after the write, `arr_wr_en` stores the whole updated row at the open row address. `persisted` then pulses high for one cycle and `busy` falls.
- R5: A write that arrives while a commit is pending reloads the shadow copy and restarts the persistence count. Exactly one array write follows, and it holds every word written before it.
- R6: A precharge during a pending commit does not cancel the commit. An activate of the same row before that commit lands loads the latest shadow copy and not the stale array contents.
- R7: These commands are refused: an activate with a row open or within the precharge gap; a read or write with no row open or within the activate-to-column gap; a precharge within the activate-to-precharge or write-recovery gap. Each refusal raises `cmd_err` for one cycle after the edge and leaves rows, data and the array untouched. A precharge with no row open is a silent no-op.
- R8: The parameters must satisfy tWR + tRP + tRCD > tPERSIST in cycles. This ensures that any pending commit belongs to the open row whenever a write is accepted.
- R9: A command whose `cmd_bank` differs from `BANK_ID` has no effect and raises no error.
- R10: With no commands, the block issues no array reads or writes (no refresh), and an open row keeps its contents.
- R11: After reset no row is open, and `busy`, `persisted`, `cmd_err` and `rd_valid` are low.
- Command codes: 0 idle, 1 activate, 2 read, 3 write, 4 precharge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd | input | 3 | Command code |
| cmd_bank | input | BANK_W | Target bank of the command |
| cmd_row | input | ROW_AW | Row address for activate |
| cmd_col | input | COL_W | Word select for read and write |
| wr_data | input | DW | Write word |
| rd_valid | output | 1 | Read word valid |
| rd_data | output | DW | Read word |
| cmd_err | output | 1 | Previous command was refused |
| busy | output | 1 | Commit pending in the shadow buffer |
| persisted | output | 1 | One-cycle pulse after a commit lands |
| arr_rd_en | output | 1 | Array row read request |
| arr_rd_row | output | ROW_AW | Array row to read |
| arr_rd_data | input | COLS*DW | Array row returned one edge after the request |
| arr_wr_en | output | 1 | Array row write strobe |
| arr_wr_row | output | ROW_AW | Array row to write |
| arr_wr_data | output | COLS*DW | Row written to the array |

## Verification
The hardest case to reach from the ports is an activate of a row whose commit has not yet landed in the array. The array read and the commit land on the same edge, so the array still returns stale data. To get there, the stimulus writes, waits the minimum write recovery, precharges, and activates the same row on the edge where the commit fires. It then reads the written word back. A second hard case is a write that restarts a pending commit. The stimulus places it one cycle before the first commit would land, then confirms that the array is unchanged at that edge and that exactly one array write occurs later.

// File: rtl/rbp_pkg.sv
package rbp_pkg;

   typedef enum logic [2:0] {
      CMD_NOP = 3'd0,
      CMD_ACT = 3'd1,
      CMD_RD  = 3'd2,
      CMD_WR  = 3'd3,
      CMD_PRE = 3'd4
   } rbp_cmd_e;

   // time in picoseconds to whole clock cycles, rounded up
   function automatic int ps2cyc(input int ps, input int clk_ps);
      return (ps + clk_ps - 1) / clk_ps;
   endfunction

endpackage

// File: rtl/rbp_gap.sv
module rbp_gap #(
   parameter int GAP = 1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic start,
   output logic clear
);
   localparam int CW = (GAP > 1) ? $clog2(GAP) : 1;

   if (GAP < 1) begin : g_bad_gap
      $error("rbp_gap: GAP must be at least one cycle");
   end

   logic [CW-1:0] cnt;

   always_ff @(posedge clk) begin
      if (!rst_n)          cnt <= '0;
      else if (start)      cnt <= CW'(GAP - 1);
      else if (cnt != '0)  cnt <= cnt - 1'b1;
   end

   assign clear = (cnt == '0);

   // R7: a command right after the starting one is still held back
   a_r7_gap_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (start && (GAP > 1)) |=> !clear);

endmodule

// File: rtl/rbp_rdpipe.sv
module rbp_rdpipe #(
   parameter int LAT = 1,
   parameter int DW  = 8
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          in_v,
   input  logic [DW-1:0] in_d,
   output logic          out_v,
   output logic [DW-1:0] out_d
);
   if (LAT < 1) begin : g_bad_lat
      $error("rbp_rdpipe: LAT must be at least one");
   end

   logic [LAT-1:0] v;
   logic [DW-1:0]  d [LAT];

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         v <= '0;
         for (int i = 0; i < LAT; i++) d[i] <= '0;
      end else begin
         v[0] <= in_v;
         d[0] <= in_d;
         for (int i = 1; i < LAT; i++) begin
            v[i] <= v[i-1];
            d[i] <= d[i-1];
         end
      end
   end

   assign out_v = v[LAT-1];
   assign out_d = d[LAT-1];

   if (LAT == 1) begin : g_chk1
      // R2: one-stage pipe presents the word right after the accepting edge
      a_r2_read_lat: assert property (@(posedge clk) disable iff (!rst_n)
         in_v |=> (out_v && out_d == $past(in_d)));
   end

endmodule

// File: rtl/rbp_shadow.sv
module rbp_shadow #(
   parameter int RAW = 4,
   parameter int RW  = 32,
   parameter int PER = 3
) (
   input  logic           clk,
   input  logic           rst_n,
   input  logic           load,
   input  logic [RAW-1:0] load_row,
   input  logic [RW-1:0]  load_data,
   output logic           busy,
   output logic           done,
   output logic [RAW-1:0] sh_row,
   output logic [RW-1:0]  sh_data,
   output logic           wr_en
);
   localparam int CW = (PER > 1) ? $clog2(PER) : 1;
   localparam int AW = $clog2(PER + 2);

   if (PER < 1) begin : g_bad_per
      $error("rbp_shadow: PER must be at least one cycle");
   end

   logic          pend;
   logic [CW-1:0] cnt;
   logic          fire;

   assign fire = pend && (cnt == '0);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         pend    <= 1'b0;
         cnt     <= '0;
         sh_row  <= '0;
         sh_data <= '0;
         done    <= 1'b0;
      end else begin
         done <= fire;
         if (load) begin
            pend    <= 1'b1;
            cnt     <= CW'(PER - 1);
            sh_row  <= load_row;
            sh_data <= load_data;
         end else if (fire) begin
            pend <= 1'b0;
         end else if (pend) begin
            cnt <= cnt - 1'b1;
         end
      end
   end

   assign busy  = pend;
   assign wr_en = fire;

   // checker-side age counter for the persistence window
   logic [AW-1:0] chk_age;
   always_ff @(posedge clk) begin
      if (!rst_n)             chk_age <= '0;
      else if (load)          chk_age <= AW'(1);
      else if (pend && !fire) chk_age <= chk_age + 1'b1;
   end

   // R4: array write lands exactly PER edges after the latest load
   a_r4_window: assert property (@(posedge clk) disable iff (!rst_n)
      wr_en |-> (chk_age == AW'(PER)));
   // R4: a landed commit is followed by the persisted pulse
   a_r4_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
      wr_en |=> done);
   // R5: a reload restarts the window, so no write lands on the next edge
   a_r5_restart: assert property (@(posedge clk) disable iff (!rst_n)
      (load && (PER > 1)) |=> (busy && !wr_en));

endmodule

// File: rtl/rbp_ctrl.sv
module rbp_ctrl import rbp_pkg::*; #(
   parameter int DW         = 8,
   parameter int COLS       = 4,
   parameter int ROW_AW     = 4,
   parameter int BANK_W     = 2,
   parameter int BANK_ID    = 1,
   parameter int CLK_PS     = 20000,
   parameter int T_RCD_PS   = 23000,
   parameter int T_AA_PS    = 13500,
   parameter int T_RAS_PS   = 32000,
   parameter int T_RP_PS    = 14250,
   parameter int T_WR_PS    = 23000,
   parameter int T_PER_PS   = 46250,
   localparam int COL_W     = (COLS > 1) ? $clog2(COLS) : 1,
   localparam int RW        = COLS * DW
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [2:0]        cmd,
   input  logic [BANK_W-1:0] cmd_bank,
   input  logic [ROW_AW-1:0] cmd_row,
   input  logic [COL_W-1:0]  cmd_col,
   input  logic [DW-1:0]     wr_data,
   output logic              rd_valid,
   output logic [DW-1:0]     rd_data,
   output logic              cmd_err,
   output logic              busy,
   output logic              persisted,
   output logic              arr_rd_en,
   output logic [ROW_AW-1:0] arr_rd_row,
   input  logic [RW-1:0]     arr_rd_data,
   output logic              arr_wr_en,
   output logic [ROW_AW-1:0] arr_wr_row,
   output logic [RW-1:0]     arr_wr_data
);
   localparam int T_RCD = ps2cyc(T_RCD_PS, CLK_PS);
   localparam int T_AA  = ps2cyc(T_AA_PS,  CLK_PS);
   localparam int T_RAS = ps2cyc(T_RAS_PS, CLK_PS);
   localparam int T_RP  = ps2cyc(T_RP_PS,  CLK_PS);
   localparam int T_WR  = ps2cyc(T_WR_PS,  CLK_PS);
   localparam int T_PER = ps2cyc(T_PER_PS, CLK_PS);
   localparam int NGAP  = 4;
   localparam int GAPS [NGAP] = '{T_RCD, T_RAS, T_RP, T_WR};
   localparam int G_RCD = 0, G_RAS = 1, G_RP = 2, G_WR = 3;

   // elaboration-time parameter checks
   if (COLS < 2 || (1 << COL_W) != COLS) begin : g_bad_cols
      $error("rbp_ctrl: COLS must be a power of two, at least 2");
   end
   if (T_RCD < 2) begin : g_bad_rcd
      $error("rbp_ctrl: activate-to-column gap must be at least 2 cycles");
   end
   if (T_WR + T_RP + T_RCD <= T_PER) begin : g_bad_per
      $error("rbp_ctrl: commit could outlive its row (R8)");
   end
   if (BANK_ID >= (1 << BANK_W)) begin : g_bad_bank
      $error("rbp_ctrl: BANK_ID does not fit in BANK_W");
   end

   // command decode
   logic mine, is_act, is_rd, is_wr, is_pre;
   assign mine   = (cmd_bank == BANK_W'(BANK_ID));
   assign is_act = mine && (cmd == CMD_ACT);
   assign is_rd  = mine && (cmd == CMD_RD);
   assign is_wr  = mine && (cmd == CMD_WR);
   assign is_pre = mine && (cmd == CMD_PRE);

   // bank state
   logic              open_q;
   logic [ROW_AW-1:0] open_row;
   logic [RW-1:0]     rowbuf;
   logic              load_q, fwd_q;
   logic [RW-1:0]     newrow;
   logic [DW-1:0]     col_word;

   // timing gaps
   logic [NGAP-1:0] gap_start, gap_clear;
   logic act_go, rd_go, wr_go, pre_go, col_ok, err;

   for (genvar g = 0; g < NGAP; g++) begin : g_gap
      rbp_gap #(.GAP(GAPS[g])) u_gap (
         .clk   (clk),
         .rst_n (rst_n),
         .start (gap_start[g]),
         .clear (gap_clear[g])
      );
   end

   assign col_ok = open_q && gap_clear[G_RCD];
   assign act_go = is_act && !open_q && gap_clear[G_RP];
   assign rd_go  = is_rd && col_ok;
   assign wr_go  = is_wr && col_ok;
   assign pre_go = is_pre && open_q && gap_clear[G_RAS] && gap_clear[G_WR];
   assign err    = (is_act && !act_go) || (is_rd && !rd_go) ||
                   (is_wr && !wr_go) || (is_pre && open_q && !pre_go);

   assign gap_start[G_RCD] = act_go;
   assign gap_start[G_RAS] = act_go;
   assign gap_start[G_RP]  = pre_go;
   assign gap_start[G_WR]  = wr_go;

   assign col_word = rowbuf[int'(cmd_col)*DW +: DW];

   always_comb begin
      newrow = rowbuf;
      newrow[int'(cmd_col)*DW +: DW] = wr_data;
   end

   // shadow buffer and commit engine
   logic [ROW_AW-1:0] sh_row;
   logic [RW-1:0]     sh_data;

   rbp_shadow #(.RAW(ROW_AW), .RW(RW), .PER(T_PER)) u_shadow (
      .clk       (clk),
      .rst_n     (rst_n),
      .load      (wr_go),
      .load_row  (open_row),
      .load_data (newrow),
      .busy      (busy),
      .done      (persisted),
      .sh_row    (sh_row),
      .sh_data   (sh_data),
      .wr_en     (arr_wr_en)
   );

   assign arr_wr_row  = sh_row;
   assign arr_wr_data = sh_data;
   assign arr_rd_en   = act_go;
   assign arr_rd_row  = cmd_row;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         open_q   <= 1'b0;
         open_row <= '0;
         rowbuf   <= '0;
         load_q   <= 1'b0;
         fwd_q    <= 1'b0;
         cmd_err  <= 1'b0;
      end else begin
         cmd_err <= err;
         load_q  <= act_go;
         if (act_go) begin
            open_q   <= 1'b1;
            open_row <= cmd_row;
            fwd_q    <= busy && (sh_row == cmd_row);
         end
         if (pre_go) open_q <= 1'b0;
         if (load_q)     rowbuf <= fwd_q ? sh_data : arr_rd_data;
         else if (wr_go) rowbuf <= newrow;
      end
   end

   rbp_rdpipe #(.LAT(T_AA), .DW(DW)) u_rdpipe (
      .clk   (clk),
      .rst_n (rst_n),
      .in_v  (rd_go),
      .in_d  (col_word),
      .out_v (rd_valid),
      .out_d (rd_data)
   );

   // R10: the array is read only on an activate aimed at this bank
   a_r10_rd_on_act: assert property (@(posedge clk) disable iff (!rst_n)
      arr_rd_en |-> (cmd == CMD_ACT && mine));
   // R7: a column command to a closed bank is reported
   a_r7_closed_col: assert property (@(posedge clk) disable iff (!rst_n)
      ((is_rd || is_wr) && !open_q) |=> cmd_err);
   // R1: an accepted activate leaves the bank open
   a_r1_opens: assert property (@(posedge clk) disable iff (!rst_n)
      arr_rd_en |=> open_q);
   // R8: any pending commit belongs to the open row when a write is accepted
   a_r8_same_row: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_go && busy) |-> (sh_row == open_row));
   // R9: a foreign-bank command never raises an error
   a_r9_foreign: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd != CMD_NOP && !mine) |=> !cmd_err);

endmodule

// File: tb/sim_rbp_ctrl.sv
module sim_rbp_ctrl;
   localparam int DW = 8, COLS = 4, RAW = 4, BW = 2, RW = 32;
   localparam int CLK_PS = 20000;
   localparam int T_RCD = (23000 + CLK_PS - 1) / CLK_PS;
   localparam int T_PER = (46250 + CLK_PS - 1) / CLK_PS;

   logic clk = 1'b0, rst_n = 1'b0;
   logic [2:0] cmd = 3'd0;
   logic [BW-1:0] cmd_bank = '0;
   logic [RAW-1:0] cmd_row = '0;
   logic [1:0] cmd_col = '0;
   logic [DW-1:0] wr_data = '0;
   logic rd_valid, cmd_err, busy, persisted, arr_rd_en, arr_wr_en;
   logic [DW-1:0] rd_data;
   logic [RAW-1:0] arr_rd_row, arr_wr_row;
   logic [RW-1:0] arr_rd_data = '0, arr_wr_data;

   always #10 clk = ~clk;

   rbp_ctrl u0 (.clk(clk), .rst_n(rst_n), .cmd(cmd), .cmd_bank(cmd_bank),
      .cmd_row(cmd_row), .cmd_col(cmd_col), .wr_data(wr_data),
      .rd_valid(rd_valid), .rd_data(rd_data), .cmd_err(cmd_err), .busy(busy),
      .persisted(persisted), .arr_rd_en(arr_rd_en), .arr_rd_row(arr_rd_row),
      .arr_rd_data(arr_rd_data), .arr_wr_en(arr_wr_en), .arr_wr_row(arr_wr_row),
      .arr_wr_data(arr_wr_data));

   // synchronous array model
   logic [RW-1:0] mem [16];
   logic [RW-1:0] exp_mem [16];
   always @(posedge clk) begin
      if (arr_wr_en) mem[arr_wr_row] <= arr_wr_data;
      if (arr_rd_en) arr_rd_data <= mem[arr_rd_row];
   end

   int total = 0, bad = 0, commits = 0, rd_reqs = 0;
   bit done = 1'b0;
   logic [DW-1:0] q_data[$];
   string q_tag[$];
   logic [RW-1:0] buf_m;

   task automatic chk(input string tag, input logic [RW-1:0] act, input logic [RW-1:0] exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   task automatic issue(input logic [2:0] c, input int bank, input int row,
                        input int col, input logic [DW-1:0] d);
      cmd = c; cmd_bank = BW'(bank); cmd_row = RAW'(row);
      cmd_col = 2'(col); wr_data = d;
      @(negedge clk);
      cmd = 3'd0;
   endtask

   task automatic idle(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic rd(input int col, input string tag);
      q_data.push_back(buf_m[col*DW +: DW]);
      q_tag.push_back(tag);
      issue(3'd2, 1, 0, col, 8'h00);
      chk({tag, " read accepted"}, RW'(cmd_err), 0);
   endtask

   task automatic wr(input int col, input logic [DW-1:0] d, input string tag);
      buf_m[col*DW +: DW] = d;
      issue(3'd3, 1, 0, col, d);
      chk({tag, " write accepted"}, RW'(cmd_err), 0);
   endtask

   // scoreboard monitor, sampling away from the active edge
   always @(posedge clk) begin
      #1;
      if (rst_n) begin
         if (arr_wr_en) commits++;
         if (arr_rd_en) rd_reqs++;
         if (rd_valid) begin
            if (q_data.size() == 0) chk("R2 unexpected read word", RW'(rd_data), 'x);
            else chk({q_tag.pop_front(), " read word"}, RW'(rd_data), RW'(q_data.pop_front()));
         end
      end
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         total++; bad++;
         $display("FAIL watchdog all-requirements actual=hung expected=finished");
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   initial begin
      int c0, r0;
      for (int i = 0; i < 16; i++) begin
         mem[i] = 32'hA0B0C0D0 ^ (i * 32'h01030507);
         exp_mem[i] = mem[i];
      end
      idle(3);
      rst_n = 1'b1;
      @(negedge clk);
      // R11 reset state
      chk("R11 busy", RW'(busy), 0);
      chk("R11 persisted", RW'(persisted), 0);
      chk("R11 cmd_err", RW'(cmd_err), 0);
      chk("R11 rd_valid", RW'(rd_valid), 0);

      // R9: foreign bank ignored; the later read proves nothing opened
      issue(3'd1, 2, 3, 0, 0);
      chk("R9 foreign act no error", RW'(cmd_err), 0);
      idle(2);
      issue(3'd3, 0, 0, 1, 8'hEE);
      chk("R9 foreign write no error", RW'(cmd_err), 0);
      issue(3'd2, 1, 0, 0, 0);
      chk("R7 read on closed bank refused", RW'(cmd_err), 1);

      // R1 open row 3; R7 early read refused
      issue(3'd1, 1, 3, 0, 0);
      chk("R1 act accepted", RW'(cmd_err), 0);
      buf_m = exp_mem[3];
      issue(3'd2, 1, 0, 0, 0);
      chk("R7 read inside tRCD refused", RW'(cmd_err), 1);
      for (int c = 0; c < COLS; c++) rd(c, "R1 R2 row load");
      issue(3'd1, 1, 6, 0, 0);
      chk("R7 act while open refused", RW'(cmd_err), 1);
      rd(2, "R7 row kept after refused act");

      // R3 R4 write, read back, persistence timing
      wr(1, 8'hA5, "R4");
      chk("R4 busy after write", RW'(busy), 1);
      chk("R4 no pulse yet", RW'(persisted), 0);
      rd(1, "R3 read after write");
      idle(T_PER - 2);
      chk("R4 array old before window", mem[3], exp_mem[3]);
      chk("R4 busy in window", RW'(busy), 1);
      idle(1);
      chk("R4 persisted pulse", RW'(persisted), 1);
      chk("R4 busy cleared", RW'(busy), 0);
      chk("R4 array holds row", mem[3], buf_m);
      exp_mem[3] = buf_m;
      idle(1);
      chk("R4 pulse one cycle", RW'(persisted), 0);

      // R5 restart of a pending commit
      c0 = commits;
      wr(2, 8'h11, "R5 first");
      idle(1);
      wr(3, 8'h22, "R5 second");
      idle(1);
      chk("R5 no commit at old deadline", mem[3], exp_mem[3]);
      chk("R5 still busy", RW'(busy), 1);
      chk("R5 no pulse", RW'(persisted), 0);
      idle(T_PER - 2);
      idle(1);
      chk("R5 persisted", RW'(persisted), 1);
      chk("R5 array holds both words", mem[3], buf_m);
      chk("R5 single array write", RW'(commits - c0), 1);
      exp_mem[3] = buf_m;

      // R7 write recovery, R6 precharge during commit and forwarding
      wr(0, 8'h77, "R6");
      issue(3'd4, 1, 0, 0, 0);
      chk("R7 precharge inside tWR refused", RW'(cmd_err), 1);
      issue(3'd4, 1, 0, 0, 0);
      chk("R6 precharge accepted while busy", RW'(cmd_err), 0);
      chk("R6 commit still pending", RW'(busy), 1);
      issue(3'd1, 1, 3, 0, 0);
      chk("R6 reopen accepted", RW'(cmd_err), 0);
      chk("R6 commit finished after precharge", RW'(persisted), 1);
      chk("R6 array updated", mem[3], buf_m);
      exp_mem[3] = buf_m;
      idle(T_RCD - 1);
      rd(0, "R6 forwarded word");
      rd(3, "R6 forwarded row");

      // R7 tRAS refusal with no effect
      issue(3'd4, 1, 0, 0, 0);
      chk("R7 precharge accepted", RW'(cmd_err), 0);
      issue(3'd1, 1, 9, 0, 0);
      buf_m = exp_mem[9];
      issue(3'd4, 1, 0, 0, 0);
      chk("R7 precharge inside tRAS refused", RW'(cmd_err), 1);
      rd(2, "R7 row stays open");

      // R8 commit to row 9 ends before row 4 can be written
      wr(0, 8'h5A, "R8 row9");
      exp_mem[9] = buf_m;
      idle(1);
      issue(3'd4, 1, 0, 0, 0);
      issue(3'd1, 1, 4, 0, 0);
      buf_m = exp_mem[4];
      chk("R8 old commit landed", mem[9], exp_mem[9]);
      idle(1);
      wr(3, 8'hC3, "R8 row4");
      idle(T_PER);
      chk("R8 row4 committed", mem[4], buf_m);
      chk("R8 row9 intact", mem[9], exp_mem[9]);
      exp_mem[4] = buf_m;

      // R10 no background activity while idle
      c0 = commits; r0 = rd_reqs;
      idle(300);
      chk("R10 no array writes idle", RW'(commits - c0), 0);
      chk("R10 no array reads idle", RW'(rd_reqs - r0), 0);
      chk("R10 not busy", RW'(busy), 0);
      rd(3, "R10 data kept");
      rd(0, "R10 data kept");
      idle(4);
      chk("R2 all reads answered", RW'(q_data.size()), 0);

      done = 1'b1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule